// File: doc/BRIEF.md
# Prioritised Vectored Interrupt Controller

This block collects interrupt requests from eight I/O devices and three internal fault sources. It merges them into a single request line toward the processor. When the processor acknowledges, the block decides which source is serviced. The acknowledge walks through a fixed-order chain, and the first eligible source in the chain takes it. Fault sources sit at the head of the chain, so they always beat I/O devices. The winner's binary type code is put on a code bus. One cycle later, a programmable table turns that code into a 16-bit service-routine start address.

Requests arrive asynchronously, so each one passes through a two-flop synchroniser. It is then held in a pending bit until that source is acknowledged. The request line is raised only in a cycle in which the processor marks an instruction boundary.

I/O sources are gated by two controls:
- a per-source mask input;
- a global enable bit, which the acknowledge clears and software sets again with a pulse.

Fault sources ignore both of these controls.

Top module: `vint_chain_ctrl`

## Requirements
- R1: `intr` goes from low to high only on the clock edge that follows a cycle with `instrEnd` high; while `instrEnd` stays low, `intr` cannot rise.
- R2: Once high, `intr` stays high until the first clock edge at which `inta` is sampled high; at that edge it falls.
- R3: An `inta` sampled high while `intr` is high makes `codeValid` a one-cycle pulse in the next cycle, with the winner's code on `intCode`.
- R4: The winner is the first eligible source in this chain order: fault 0, fault 1, fault 2, then I/O 0 through I/O 7. A pending fault therefore always beats any I/O source.
- R5: The code of I/O source i is i (0..7). The code of fault source j is 8+j (8..10).
- R6: `vecValid` pulses in the cycle after `codeValid`. `vecAddr` then holds the table entry indexed by that code.
- R7: An I/O source whose `ioMask` bit is 1 is never selected and never raises `intr`. Its pending state is kept, and it is serviced once the mask bit returns to 0.
- R8: The global enable resets to 0. A one-cycle `ieSet` pulse sets it, and every serviced acknowledge clears it. While it is 0, I/O sources cannot raise `intr` or win, but fault sources still can.
- R9: A request pulse of at least two cycles is held pending. Each acknowledge clears only the winner, and the other pending sources are served one per acknowledge.
- R10: An `inta` sampled while `intr` is low has no effect: no `codeValid` and no `vecValid` follow.
- R11: A write with `cfgWe` high stores `cfgData` into table entry `cfgAddr` (0..10). Later acknowledges of that code return the new value.
- R12: After reset, `intr`, `codeValid` and `vecValid` are low, and every table entry is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| ioReq | input | 8 | Asynchronous I/O device requests |
| fltReq | input | 3 | Asynchronous internal fault requests (non-maskable) |
| ioMask | input | 8 | Per-device mask, 1 holds the device off |
| instrEnd | input | 1 | Processor is at an instruction boundary |
| ieSet | input | 1 | Pulse that sets the global enable |
| inta | input | 1 | Acknowledge from the processor |
| cfgWe | input | 1 | Vector table write strobe |
| cfgAddr | input | 4 | Vector table entry to write |
| cfgData | input | 16 | Routine address to store |
| intr | output | 1 | Merged request to the processor |
| intCode | output | 4 | Type code of the serviced source |
| codeValid | output | 1 | One-cycle strobe marking `intCode` |
| vecAddr | output | 16 | Routine start address from the table |
| vecValid | output | 1 | One-cycle strobe marking `vecAddr` |

## Verification
The properties assume three things about the inputs:
- `inta` is a one-cycle pulse.
- Requests are held for at least two clock cycles, so the synchroniser sees them.
- Table writes name only codes 0 to 10.

The bench keeps to these limits. Every acknowledge is a single-cycle pulse driven at the falling edge. Every request pulse lasts two cycles and is dropped well before the acknowledge. Only the eleven valid table entries are written.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int DEF_NUM_IO  = 8;
  localparam int DEF_NUM_FLT = 3;
  localparam int DEF_ADDR_W  = 16;

  // Strobes from control to datapath
  typedef struct packed {
    logic ackTake;  // qualified acknowledge entering the chain
    logic ieOn;     // global enable for I/O sources
  } irqStrb_t;
endpackage

// File: rtl/irqc_sync.sv
module irqc_sync #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      meta <= '0;
      q    <= '0;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/irqc_control.sv
module irqc_control import irqc_pkg::*; (
  input  logic     clk,
  input  logic     rstN,
  input  logic     instrEnd,
  input  logic     inta,
  input  logic     ieSet,
  input  logic     anyElig,
  input  logic     granted,
  output logic     intr,
  output irqStrb_t strb
);
  logic intrQ;
  logic ieQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intrQ <= 1'b0;
    end else if (intrQ) begin
      intrQ <= !inta;
    end else begin
      intrQ <= instrEnd && anyElig;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ieQ <= 1'b0;
    end else if (granted) begin
      ieQ <= 1'b0;
    end else if (ieSet) begin
      ieQ <= 1'b1;
    end
  end

  assign intr         = intrQ;
  assign strb.ackTake = inta && intrQ;
  assign strb.ieOn    = ieQ;

  p_boundary_rise_r1: assert property (@(posedge clk) disable iff (!rstN)
    $rose(intrQ) |-> $past(instrEnd));

  p_hold_until_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    intrQ && !inta |=> intrQ);

  p_drop_on_ack_r2: assert property (@(posedge clk) disable iff (!rstN)
    intrQ && inta |=> !intrQ);
endmodule

// File: rtl/irqc_datapath.sv
module irqc_datapath import irqc_pkg::*; #(
  parameter  int NUM_IO  = DEF_NUM_IO,
  parameter  int NUM_FLT = DEF_NUM_FLT,
  parameter  int ADDR_W  = DEF_ADDR_W,
  localparam int NUM_SRC = NUM_IO + NUM_FLT,
  localparam int CODE_W  = $clog2(NUM_SRC)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [NUM_IO-1:0]  ioReqA,
  input  logic [NUM_FLT-1:0] fltReqA,
  input  logic [NUM_IO-1:0]  ioMask,
  input  irqStrb_t           strb,
  input  logic               cfgWe,
  input  logic [CODE_W-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgData,
  output logic               anyElig,
  output logic               granted,
  output logic [CODE_W-1:0]  intCode,
  output logic               codeValid,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               vecValid
);
  localparam logic [CODE_W-1:0] SRC_LAST = CODE_W'(NUM_SRC - 1);
  localparam logic [CODE_W-1:0] FLT_BASE = CODE_W'(NUM_IO);

  logic [NUM_IO-1:0]  ioSync, ioPend;
  logic [NUM_FLT-1:0] fltSync, fltPend;
  logic [NUM_SRC-1:0] elig, grant, ackRip;
  logic [CODE_W-1:0]  codeNext, intCodeQ;
  logic               codeValidQ, vecValidQ;
  logic [ADDR_W-1:0]  vecAddrQ;
  logic [ADDR_W-1:0]  vecTbl [NUM_SRC];

  irqc_sync #(.W(NUM_IO))  u_ioSync  (.clk(clk), .rstN(rstN), .d(ioReqA),  .q(ioSync));
  irqc_sync #(.W(NUM_FLT)) u_fltSync (.clk(clk), .rstN(rstN), .d(fltReqA), .q(fltSync));

  // Pending bits: set by request, cleared by own grant
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ioPend  <= '0;
      fltPend <= '0;
    end else begin
      ioPend  <= (ioPend  | ioSync)  & ~grant[NUM_SRC-1:NUM_FLT];
      fltPend <= (fltPend | fltSync) & ~grant[NUM_FLT-1:0];
    end
  end

  // Chain order: faults first, then I/O in index order
  assign elig = {ioPend & ~ioMask & {NUM_IO{strb.ieOn}}, fltPend};

  assign ackRip[0] = strb.ackTake;
  for (genvar k = 0; k < NUM_SRC; k++) begin : g_chain
    assign grant[k] = ackRip[k] && elig[k];
    if (k < NUM_SRC - 1) begin : g_pass
      assign ackRip[k+1] = ackRip[k] && !elig[k];
    end
  end

  function automatic logic [CODE_W-1:0] srcCode(input int k);
    if (k < NUM_FLT) return CODE_W'(NUM_IO + k);
    return CODE_W'(k - NUM_FLT);
  endfunction

  always_comb begin
    codeNext = '0;
    for (int k = 0; k < NUM_SRC; k++) begin
      if (grant[k]) codeNext = codeNext | srcCode(k);
    end
  end

  assign granted = |grant;
  assign anyElig = |elig;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      codeValidQ <= 1'b0;
      intCodeQ   <= '0;
    end else begin
      codeValidQ <= granted;
      if (granted) intCodeQ <= codeNext;
    end
  end

  // Vector table, written through the configuration port
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_SRC; i++) vecTbl[i] <= '0;
    end else if (cfgWe && cfgAddr <= SRC_LAST) begin
      vecTbl[cfgAddr] <= cfgData;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      vecValidQ <= 1'b0;
      vecAddrQ  <= '0;
    end else begin
      vecValidQ <= codeValidQ;
      if (codeValidQ) vecAddrQ <= vecTbl[intCodeQ];
    end
  end

  assign intCode   = intCodeQ;
  assign codeValid = codeValidQ;
  assign vecAddr   = vecAddrQ;
  assign vecValid  = vecValidQ;

  p_single_winner_r4: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(grant));

  p_fault_first_r4: assert property (@(posedge clk) disable iff (!rstN)
    codeValidQ && $past(fltPend != '0) |-> intCodeQ >= FLT_BASE);

  p_code_range_r5: assert property (@(posedge clk) disable iff (!rstN)
    codeValidQ |-> intCodeQ <= SRC_LAST);

  p_code_needs_ack_r3: assert property (@(posedge clk) disable iff (!rstN)
    codeValidQ |-> $past(strb.ackTake));

  p_vec_follows_r6: assert property (@(posedge clk) disable iff (!rstN)
    vecValidQ |-> $past(codeValidQ));

  p_ie_cleared_r8: assert property (@(posedge clk) disable iff (!rstN)
    codeValidQ |-> !strb.ieOn);

  for (genvar k = 0; k < NUM_IO; k++) begin : g_chk
    p_masked_held_r7: assert property (@(posedge clk) disable iff (!rstN)
      ioMask[k] |-> !grant[NUM_FLT + k]);
    p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rstN)
      grant[NUM_FLT + k] |=> !ioPend[k]);
  end
endmodule

// File: rtl/vint_chain_ctrl.sv
module vint_chain_ctrl import irqc_pkg::*; #(
  parameter  int NUM_IO  = DEF_NUM_IO,
  parameter  int NUM_FLT = DEF_NUM_FLT,
  parameter  int ADDR_W  = DEF_ADDR_W,
  localparam int NUM_SRC = NUM_IO + NUM_FLT,
  localparam int CODE_W  = $clog2(NUM_SRC)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [NUM_IO-1:0]  ioReq,
  input  logic [NUM_FLT-1:0] fltReq,
  input  logic [NUM_IO-1:0]  ioMask,
  input  logic               instrEnd,
  input  logic               ieSet,
  input  logic               inta,
  input  logic               cfgWe,
  input  logic [CODE_W-1:0]  cfgAddr,
  input  logic [ADDR_W-1:0]  cfgData,
  output logic               intr,
  output logic [CODE_W-1:0]  intCode,
  output logic               codeValid,
  output logic [ADDR_W-1:0]  vecAddr,
  output logic               vecValid
);
  irqStrb_t strb;
  logic     anyElig;
  logic     granted;

  irqc_control u_ctrl (
    .clk(clk), .rstN(rstN), .instrEnd(instrEnd), .inta(inta), .ieSet(ieSet),
    .anyElig(anyElig), .granted(granted), .intr(intr), .strb(strb)
  );

  irqc_datapath #(.NUM_IO(NUM_IO), .NUM_FLT(NUM_FLT), .ADDR_W(ADDR_W)) u_dp (
    .clk(clk), .rstN(rstN), .ioReqA(ioReq), .fltReqA(fltReq), .ioMask(ioMask),
    .strb(strb), .cfgWe(cfgWe), .cfgAddr(cfgAddr), .cfgData(cfgData),
    .anyElig(anyElig), .granted(granted), .intCode(intCode),
    .codeValid(codeValid), .vecAddr(vecAddr), .vecValid(vecValid)
  );

  p_stray_ack_r10: assert property (@(posedge clk) disable iff (!rstN)
    !intr && inta |=> !codeValid);
endmodule

// File: tb/vint_chain_ctrl_bench.sv
module vint_chain_ctrl_bench;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  ioReq = '0;
  logic [2:0]  fltReq = '0;
  logic [7:0]  ioMask = '0;
  logic        instrEnd = 1'b1;
  logic        ieSet = 1'b0;
  logic        inta = 1'b0;
  logic        cfgWe = 1'b0;
  logic [3:0]  cfgAddr = '0;
  logic [15:0] cfgData = '0;
  logic        intr, codeValid, vecValid;
  logic [3:0]  intCode;
  logic [15:0] vecAddr;

  int errCnt = 0;
  int chkCnt = 0;
  bit done = 1'b0;
  logic [15:0] shadow [11];

  always #5 clk = ~clk;

  vint_chain_ctrl u_vint_chain_ctrl (
    .clk(clk), .rstN(rstN), .ioReq(ioReq), .fltReq(fltReq), .ioMask(ioMask),
    .instrEnd(instrEnd), .ieSet(ieSet), .inta(inta), .cfgWe(cfgWe),
    .cfgAddr(cfgAddr), .cfgData(cfgData), .intr(intr), .intCode(intCode),
    .codeValid(codeValid), .vecAddr(vecAddr), .vecValid(vecValid)
  );

  typedef struct packed {
    logic [7:0] io;
    logic [2:0] flt;
    logic [7:0] msk;
    logic [3:0] code;
  } step_t;

  localparam step_t STEPS [9] = '{
    '{8'h24, 3'b000, 8'h00, 4'd2},
    '{8'h00, 3'b000, 8'h00, 4'd5},
    '{8'h80, 3'b010, 8'h00, 4'd9},
    '{8'h00, 3'b000, 8'h00, 4'd7},
    '{8'h03, 3'b000, 8'h01, 4'd1},
    '{8'h00, 3'b000, 8'h00, 4'd0},
    '{8'h10, 3'b101, 8'h00, 4'd8},
    '{8'h00, 3'b000, 8'h00, 4'd10},
    '{8'h00, 3'b000, 8'h00, 4'd4}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    chkCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic writeTbl(input int idx, input logic [15:0] val);
    cfgWe = 1'b1; cfgAddr = 4'(idx); cfgData = val;
    cyc(1);
    cfgWe = 1'b0;
    shadow[idx] = val;
  endtask

  task automatic pulse(input logic [7:0] io, input logic [2:0] flt, input bit setIe);
    ioReq = io; fltReq = flt; ieSet = setIe;
    cyc(1);
    ieSet = 1'b0;
    cyc(1);
    ioReq = '0; fltReq = '0;
  endtask

  // Acknowledge once and check code and vector
  task automatic ackCheck(input string req, input logic [3:0] expCode);
    inta = 1'b1;
    cyc(1);
    inta = 1'b0;
    chk({req, " codeValid"}, 32'(codeValid), 32'd1);
    chk({req, " intCode"}, 32'(intCode), 32'(expCode));
    chk({req, " intr after ack"}, 32'(intr), 32'd0);
    cyc(1);
    chk({req, " codeValid one cycle"}, 32'(codeValid), 32'd0);
    chk({req, " vecValid"}, 32'(vecValid), 32'd1);
    chk({req, " vecAddr"}, 32'(vecAddr), 32'(shadow[expCode]));
  endtask

  initial begin
    for (int i = 0; i < 11; i++) shadow[i] = '0;
    cyc(3);
    // R12 reset state
    chk("R12 intr", 32'(intr), 32'd0);
    chk("R12 codeValid", 32'(codeValid), 32'd0);
    chk("R12 vecValid", 32'(vecValid), 32'd0);
    rstN = 1'b1;
    cyc(2);
    // R12 table cleared: fault 0 with zero table entry
    pulse(8'h00, 3'b001, 1'b0);
    cyc(6);
    ackCheck("R12 table zero", 4'd8);
    cyc(2);

    // R11 load table
    for (int i = 0; i < 11; i++) writeTbl(i, 16'h0400 + 16'(i) * 16'h0123);

    // Table walk: R4 R5 R6 R7 R9 R3
    for (int s = 0; s < 9; s++) begin
      ioMask = STEPS[s].msk;
      pulse(STEPS[s].io, STEPS[s].flt, 1'b1);
      cyc(6);
      chk("R9 intr pending", 32'(intr), 32'd1);
      ackCheck("R4 R5 R6 R7 walk", STEPS[s].code);
      cyc(2);
    end
    ioMask = '0;

    // R10 stray acknowledge
    chk("R10 intr idle", 32'(intr), 32'd0);
    inta = 1'b1;
    cyc(1);
    inta = 1'b0;
    chk("R10 no codeValid", 32'(codeValid), 32'd0);
    cyc(1);
    chk("R10 no vecValid", 32'(vecValid), 32'd0);

    // R8 enable off blocks I/O, not faults
    pulse(8'h08, 3'b000, 1'b0);
    cyc(8);
    chk("R8 io blocked", 32'(intr), 32'd0);
    pulse(8'h00, 3'b001, 1'b0);
    cyc(6);
    chk("R8 fault passes", 32'(intr), 32'd1);
    ackCheck("R8 fault", 4'd8);
    cyc(6);
    chk("R8 io still blocked", 32'(intr), 32'd0);
    ieSet = 1'b1; cyc(1); ieSet = 1'b0;
    cyc(3);
    ackCheck("R8 io after set", 4'd3);

    // R8 auto-clear after service
    pulse(8'h40, 3'b000, 1'b0);
    cyc(8);
    chk("R8 auto cleared", 32'(intr), 32'd0);

    // R1 boundary gating, R2 hold
    instrEnd = 1'b0;
    ieSet = 1'b1; cyc(1); ieSet = 1'b0;
    cyc(10);
    chk("R1 no boundary", 32'(intr), 32'd0);
    instrEnd = 1'b1;
    cyc(1);
    chk("R1 rises at boundary", 32'(intr), 32'd1);
    instrEnd = 1'b0;
    cyc(15);
    chk("R2 held", 32'(intr), 32'd1);
    instrEnd = 1'b1;
    ackCheck("R2 ack", 4'd6);

    // R11 rewrite one entry
    writeTbl(2, 16'hBEEF);
    pulse(8'h04, 3'b000, 1'b1);
    cyc(6);
    ackCheck("R11 rewrite", 4'd2);

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errCnt++;
      chkCnt++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errCnt, chkCnt);
      $finish;
    end
  end
endmodule